// File: doc/BRIEF.md
# ARINC 429 Receive Word Screener

This block sits after the bit-level deserializer of one ARINC 429 receive channel. For every completed 32-bit word it decides whether the word goes on to the receive FIFO or is dropped. A 16-bit control register sets how it decides. That register selects the input source, which is either the external line or a loopback from an internal test transmitter. It also holds the channel enable, the parity check enable and its sense, label filtering, and a programming mode for the label accept table.

The label is word bits 7..0. It indexes a 256-entry accept table with one bit per label. Software loads the table through a separate address/data port, and only while programming mode is on. A word whose parity check fails is dropped. When the self-test enable input is high, that failure also sets a sticky wrong-parity flag at control bit 7. Software clears the flag by writing 0 to that bit.

Top module: `a429_rx_screener`

## Requirements
- R1: While control bit 15 (channel enable) is 0, no word is forwarded.
- R2: Control bit 14 selects the source: 0 takes `line_valid`/`line_word`, 1 takes `loop_valid`/`loop_word`. The unselected source is ignored.
- R3: With control bit 13 at 0 every label passes. At 1 a word passes only if the table entry indexed by its bits 7..0 is 1.
- R4: Table writes take effect only while control bit 12 (programming mode) is 1. While bit 12 is 1, no word is forwarded.
- R5: With control bit 10 at 1, parity is checked over all 32 bits. Bit 11 at 0 requires an even count of ones and at 1 requires an odd count. With bit 10 at 0, parity is not checked.
- R6: A word that fails an enabled parity check on an enabled channel is dropped. If `selftest_en` is 1 in that cycle, control bit 7 becomes 1 and stays 1.
- R7: With `selftest_en` at 0, a parity failure does not set control bit 7.
- R8: Writing the control register with bit 7 at 0 clears the wrong-parity flag. Writing 1 there leaves the flag unchanged.
- R9: Reset clears the control register and the table. Bits 9, 8 and 6..0 always read 0 apart from the flag at bit 7.
- R10: An accepted word appears unchanged on `fwd_word`, with `fwd_valid` high for exactly one cycle, in the clock cycle after its input strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 16 | Control register write data |
| ctrl_rd_data | output | 16 | Control register read value |
| selftest_en | input | 1 | Self-test enable, gates the wrong-parity flag |
| tbl_wr_en | input | 1 | Label table write strobe |
| tbl_wr_addr | input | 8 | Label table entry address |
| tbl_wr_data | input | 1 | Accept bit to write |
| line_valid | input | 1 | External line word complete |
| line_word | input | 32 | External line word |
| loop_valid | input | 1 | Loopback word complete |
| loop_word | input | 32 | Loopback word |
| fwd_valid | output | 1 | Accepted-word strobe to the FIFO |
| fwd_word | output | 32 | Accepted word |

## Verification
The hardest state to reach from the ports is a table whose contents differ from what the last table writes requested. That only happens when a write arrives outside programming mode, and the table itself can only be seen indirectly. The stimulus sets the label filter on and loads one label in programming mode. It leaves programming mode, writes another label, and then sends words carrying both labels. The bench reads the table contents from which of those words come out. The sticky flag is checked in the same spirit: parity failures are sent with self-test off and then on, and each is followed by a write with bit 7 at 1 and one with bit 7 at 0.

// File: rtl/a429_scr_pkg.sv
package a429_scr_pkg;

    localparam int CTRL_W  = 16;
    localparam int WORD_W  = 32;
    localparam int LABEL_W = 8;

    // control bit positions
    localparam int B_CHAN = 15;
    localparam int B_LOOP = 14;
    localparam int B_LBL  = 13;
    localparam int B_PROG = 12;
    localparam int B_ODD  = 11;
    localparam int B_PAR  = 10;
    localparam int B_WPAR = 7;

    localparam logic [CTRL_W-1:0] CFG_MASK =
        (16'h1 << B_CHAN) | (16'h1 << B_LOOP) | (16'h1 << B_LBL) |
        (16'h1 << B_PROG) | (16'h1 << B_ODD)  | (16'h1 << B_PAR);

    typedef struct packed {
        logic chan_en;
        logic loop_sel;
        logic lbl_chk;
        logic prog_mode;
        logic odd_sense;
        logic par_chk;
    } scr_mode_t;

    function automatic scr_mode_t decode_mode(input logic [CTRL_W-1:0] r);
        scr_mode_t m;
        m.chan_en   = r[B_CHAN];
        m.loop_sel  = r[B_LOOP];
        m.lbl_chk   = r[B_LBL];
        m.prog_mode = r[B_PROG];
        m.odd_sense = r[B_ODD];
        m.par_chk   = r[B_PAR];
        return m;
    endfunction

    function automatic logic parity_pass(input logic [WORD_W-1:0] w, input logic odd);
        return (^w) == odd;
    endfunction

endpackage

// File: rtl/a429_ctrl_regs.sv
module a429_ctrl_regs
    import a429_scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              selftest_en,
    input  logic              par_fail,
    output scr_mode_t         mode,
    output logic [CTRL_W-1:0] rd_data
);
    logic [CTRL_W-1:0] cfg_q;
    logic              wpar_q;
    logic              wpar_set;
    logic              wpar_clr;

    assign wpar_set = par_fail && selftest_en;
    assign wpar_clr = wr_en && !wr_data[B_WPAR];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            wpar_q <= 1'b0;
        end else begin
            if (wr_en)
                cfg_q <= wr_data & CFG_MASK;
            if (wpar_set)
                wpar_q <= 1'b1;
            else if (wpar_clr)
                wpar_q <= 1'b0;
        end
    end

    assign mode    = decode_mode(cfg_q);
    assign rd_data = cfg_q | (CTRL_W'(wpar_q) << B_WPAR);

    AST_FLAG_NEEDS_SELFTEST: assert property (@(posedge clk) disable iff (rst)
        $rose(wpar_q) |-> $past(selftest_en && par_fail)); // R7
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[B_WPAR] && !par_fail) |=> !rd_data[B_WPAR]); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_WPAR] && !(wr_en && !wr_data[B_WPAR])) |=> rd_data[B_WPAR]); // R6

endmodule

// File: rtl/a429_label_table.sv
module a429_label_table #(
    parameter int LABEL_W = 8,
    localparam int N_ENT  = 1 << LABEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_mode,
    input  logic               wr_en,
    input  logic [LABEL_W-1:0] wr_addr,
    input  logic               wr_data,
    input  logic [LABEL_W-1:0] rd_label,
    output logic               rd_hit
);
    logic [N_ENT-1:0] tab_q;
    logic             wr_ok;

    assign wr_ok = wr_en && prog_mode;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                tab_q[i] <= 1'b0;
            else if (wr_ok && (wr_addr == LABEL_W'(i)))
                tab_q[i] <= wr_data;
        end
    end

    assign rd_hit = tab_q[rd_label];

    AST_TABLE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !prog_mode |=> $stable(tab_q)); // R4

endmodule

// File: rtl/a429_word_judge.sv
module a429_word_judge
    import a429_scr_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int LW = LABEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  scr_mode_t     mode,
    input  logic          line_valid,
    input  logic [WW-1:0] line_word,
    input  logic          loop_valid,
    input  logic [WW-1:0] loop_word,
    output logic [LW-1:0] look_label,
    input  logic          lbl_hit,
    output logic          par_fail,
    output logic          fwd_valid,
    output logic [WW-1:0] fwd_word
);
    logic          in_vld;
    logic [WW-1:0] in_word;
    logic          par_ok;
    logic          lbl_ok;
    logic          keep;

    always_comb begin
        if (mode.loop_sel) begin
            in_vld  = loop_valid;
            in_word = loop_word;
        end else begin
            in_vld  = line_valid;
            in_word = line_word;
        end
    end

    assign look_label = in_word[LW-1:0];
    assign par_ok     = !mode.par_chk || parity_pass(WORD_W'(in_word), mode.odd_sense);
    assign lbl_ok     = !mode.lbl_chk || lbl_hit;
    assign par_fail   = in_vld && mode.chan_en && !par_ok;
    assign keep       = in_vld && mode.chan_en && !mode.prog_mode && par_ok && lbl_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid <= 1'b0;
            fwd_word  <= '0;
        end else begin
            fwd_valid <= keep;
            if (keep)
                fwd_word <= in_word;
        end
    end

    AST_NO_FWD_OFFLINE: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(mode.chan_en)); // R1
    AST_NO_FWD_PROG: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> !$past(mode.prog_mode)); // R4
    AST_FWD_PARITY: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && $past(mode.par_chk)) |-> ((^fwd_word) == $past(mode.odd_sense))); // R5
    AST_FWD_LABEL: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && $past(mode.lbl_chk)) |-> $past(lbl_hit)); // R3
    AST_FWD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(mode.loop_sel ? loop_valid : line_valid)); // R2

endmodule

// File: rtl/a429_rx_screener.sv
module a429_rx_screener
    import a429_scr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr_en,
    input  logic [CTRL_W-1:0]  ctrl_wr_data,
    output logic [CTRL_W-1:0]  ctrl_rd_data,
    input  logic               selftest_en,
    input  logic               tbl_wr_en,
    input  logic [LABEL_W-1:0] tbl_wr_addr,
    input  logic               tbl_wr_data,
    input  logic               line_valid,
    input  logic [WORD_W-1:0]  line_word,
    input  logic               loop_valid,
    input  logic [WORD_W-1:0]  loop_word,
    output logic               fwd_valid,
    output logic [WORD_W-1:0]  fwd_word
);
    scr_mode_t          mode;
    logic               par_fail;
    logic [LABEL_W-1:0] look_label;
    logic               lbl_hit;

    a429_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ctrl_wr_en),
        .wr_data    (ctrl_wr_data),
        .selftest_en(selftest_en),
        .par_fail   (par_fail),
        .mode       (mode),
        .rd_data    (ctrl_rd_data)
    );

    a429_label_table #(.LABEL_W(LABEL_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .prog_mode(mode.prog_mode),
        .wr_en    (tbl_wr_en),
        .wr_addr  (tbl_wr_addr),
        .wr_data  (tbl_wr_data),
        .rd_label (look_label),
        .rd_hit   (lbl_hit)
    );

    a429_word_judge #(.WW(WORD_W), .LW(LABEL_W)) u_judge (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .line_valid(line_valid),
        .line_word (line_word),
        .loop_valid(loop_valid),
        .loop_word (loop_word),
        .look_label(look_label),
        .lbl_hit   (lbl_hit),
        .par_fail  (par_fail),
        .fwd_valid (fwd_valid),
        .fwd_word  (fwd_word)
    );

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && !$past(line_valid) && !$past(loop_valid)) |-> 1'b0); // R10

endmodule

// File: tb/a429_rx_screener_test.sv
module a429_rx_screener_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr_en = 1'b0;
    logic [15:0] ctrl_wr_data = '0;
    logic [15:0] ctrl_rd_data;
    logic        selftest_en = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [7:0]  tbl_wr_addr = '0;
    logic        tbl_wr_data = 1'b0;
    logic        line_valid = 1'b0;
    logic [31:0] line_word = '0;
    logic        loop_valid = 1'b0;
    logic [31:0] loop_word = '0;
    logic        fwd_valid;
    logic [31:0] fwd_word;

    always #2 clk = ~clk;

    a429_rx_screener uut (.*);

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    logic [15:0] m_cfg = '0;
    logic        m_flag = 1'b0;
    logic        m_tab [256];
    bit          done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && fwd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R1/R3/R4/R6: unexpected word actual %h expected none", fwd_word);
            end else begin
                chk("R10 forwarded word", fwd_word, exp_q.pop_front());
            end
        end
    end

    function automatic logic [31:0] mk(input logic [7:0] lbl, input logic [22:0] body, input bit odd);
        logic [31:0] w = {1'b0, body, lbl};
        w[31] = (^w) ^ odd;
        return w;
    endfunction

    task automatic wr_ctrl(input logic [15:0] d);
        @(negedge clk);
        ctrl_wr_en = 1'b1; ctrl_wr_data = d;
        @(negedge clk);
        ctrl_wr_en = 1'b0;
        m_cfg = d & 16'hFC00;
        if (!d[7]) m_flag = 1'b0;
    endtask

    task automatic wr_tab(input logic [7:0] a, input logic v);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = v;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        if (m_cfg[12]) m_tab[a] = v;
    endtask

    // driver: presents both sources, predicts outcome
    task automatic send(input logic [31:0] lw, input logic [31:0] pw);
        logic [31:0] w;
        bit pok, keep;
        @(negedge clk);
        line_valid = 1'b1; line_word = lw;
        loop_valid = 1'b1; loop_word = pw;
        w    = m_cfg[14] ? pw : lw;
        pok  = !m_cfg[10] || ((^w) == m_cfg[11]);
        keep = m_cfg[15] && !m_cfg[12] && pok && (!m_cfg[13] || m_tab[w[7:0]]);
        if (m_cfg[15] && !pok && selftest_en) m_flag = 1'b1;
        if (keep) exp_q.push_back(w);
        @(negedge clk);
        line_valid = 1'b0; loop_valid = 1'b0;
    endtask

    task automatic drained(input string tag);
        @(negedge clk); @(negedge clk);
        chk(tag, exp_q.size(), 0);
    endtask

    task automatic chk_reg(input string tag);
        chk(tag, {16'h0, ctrl_rd_data}, {16'h0, m_cfg | (16'(m_flag) << 7)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (m_tab[i]) m_tab[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset
        chk("R9 reset reg", {16'h0, ctrl_rd_data}, 32'h0);
        chk("R9 reset fwd", {31'h0, fwd_valid}, 32'h0);

        // R1 channel off
        send(32'h1234_5601, 32'h0);
        drained("R1 offline drop");

        // R10, R2 line source, no checks
        wr_ctrl(16'h8000);
        chk_reg("R9 readback 8000");
        send(32'hA5A5_0011, 32'h5A5A_0022);
        send(32'h0000_00FF, 32'h0000_0001);
        drained("R2 line source");
        // R2 loop source
        wr_ctrl(16'hC000);
        send(32'hDEAD_0033, 32'hBEEF_0044);
        drained("R2 loop source");

        // R9 unused bits read 0
        wr_ctrl(16'h03FF & 16'hFF7F);
        chk_reg("R9 unused bits zero");

        // R3 label filter, empty table
        wr_ctrl(16'hA000);
        send(mk(8'h35, 23'h1, 0), '0);
        drained("R3 empty table drop");
        // R4 program label 0x35, words in prog mode dropped
        wr_ctrl(16'hB000);
        wr_tab(8'h35, 1'b1);
        send(mk(8'h35, 23'h2, 0), '0);
        drained("R4 no fwd in prog");
        wr_ctrl(16'hA000);
        wr_tab(8'h77, 1'b1);            // ignored outside prog mode
        send(mk(8'h35, 23'h3, 0), '0);  // accepted
        send(mk(8'h77, 23'h4, 0), '0);  // dropped, R4 write ignored
        send(mk(8'h36, 23'h5, 1), '0);  // dropped, R3
        drained("R3 R4 table filter");
        // R3 off: all labels again
        wr_ctrl(16'h8000);
        send(mk(8'h77, 23'h6, 1), '0);
        drained("R3 filter off");

        // R5 even parity
        wr_ctrl(16'h8400);
        send(mk(8'h10, 23'h7, 0), '0);
        send(mk(8'h11, 23'h8, 1), '0);
        drained("R5 even sense");
        // R5 odd parity, R7 no flag without self-test
        wr_ctrl(16'h8C00);
        send(mk(8'h12, 23'h9, 1), '0);
        send(mk(8'h13, 23'hA, 0), '0);
        drained("R5 odd sense");
        chk_reg("R7 flag stays clear");

        // R6 flag set with self-test
        selftest_en = 1'b1;
        send(mk(8'h14, 23'hB, 0), '0);
        drained("R6 bad word dropped");
        chk_reg("R6 flag set");
        wr_ctrl(16'h8C80);
        chk_reg("R8 write one keeps flag");
        wr_ctrl(16'h8C00);
        chk_reg("R8 write zero clears flag");
        // R1 with bad parity on offline channel: no flag
        wr_ctrl(16'h0C00);
        send(mk(8'h15, 23'hC, 0), '0);
        drained("R1 offline bad word");
        chk_reg("R6 offline no flag");
        selftest_en = 1'b0;

        drained("final drain");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule